// File: doc/BRIEF.md
# Video Timing Reference and Ancillary Packet Detector

This block watches a 10-bit parallel digital video word stream, one word per clock. It finds timing reference sequences and ancillary data packets in that stream. It delays the stream by a fixed four clocks and sends it on unchanged. Each indication it raises is aligned to the word it describes on the delayed output.

It produces three kinds of indication. The horizontal sync output follows the timing references; its shape depends on whether the stream is component or composite, which a static mode input selects. The ancillary flag marks every word of an ancillary packet, and it can also mark the words of each timing reference. A lock monitor raises a "no reference" flag when the expected references stop arriving. Hysteresis keeps that flag from toggling on isolated faults.

Top module: `vid_trs_anc_detect`

## Requirements
- R1: `dout` repeats `din` exactly four clock edges later. Every indication output refers to the word currently on `dout`.
- R2: Where a pattern calls for the all-ones word, any input value from 3FC to 3FF is accepted. Where a pattern calls for 000, only 000 is accepted.
- R3: With `comp_mode`=1, a timing reference is the run 3FF,000,000 followed by a status word whose bit 6 is H. H=1 marks an end-of-active-video reference and H=0 a start-of-active-video reference. `hsync` goes high on the first word of an end reference and stays high through the word before the first word of the next start reference.
- R4: With `comp_mode`=0, `hsync` is high for exactly one word: the first word of each 3FF,000,000 run.
- R5: An ancillary packet is the run 000,3FF,3FF, then a data ID word, a block number word, a count word and the payload words, ending with a checksum. The count is bits 7:0 of the count word. `anc_flag` is high from the first 000 through the checksum, which makes 7+count words. While a packet is open, no new packet start is recognised.
- R6: When `trs_ind_en`=1, `anc_flag` is also high from the first word of each timing reference. It stays high for 4 words in component mode and 5 words in composite mode.
- R7: A miss is counted whenever GAP_WORDS consecutive output words pass without a reference start. The miss window restarts at every reference start and at every miss. `no_trs` rises after LOSS_RUN (7) misses with no reference start between them. Fewer misses leave it low.
- R8: `no_trs` falls after LOCK_RUN (7) reference starts with no miss between them. A miss restarts that count.
- R9: `rst_n` is a synchronous, active-low reset. A clock edge with `rst_n` low clears `dout`, `hsync` and `anc_flag` and sets `no_trs`. The delay stages fill with 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| comp_mode | input | 1 | 1 = component stream, 0 = composite stream |
| trs_ind_en | input | 1 | Also mark timing reference words on `anc_flag` |
| din | input | 10 | Incoming video word |
| dout | output | 10 | Video word delayed by four clocks |
| hsync | output | 1 | Horizontal sync indication for the word on `dout` |
| anc_flag | output | 1 | Ancillary packet (and optionally reference) marker for the word on `dout` |
| no_trs | output | 1 | Timing references lost |

## Verification
The bench builds the block with GAP_WORDS set to 128 and keeps the default loss and lock runs of seven. The short window makes a full seven-miss loss and its recovery happen within about a thousand words. It also reaches the partial cases: a single miss that breaks a recovery streak, and three misses that must not drop lock. Line lengths stay well under the window, so the bench controls every miss exactly. Packets with count values from 0 to 19 and both operating modes, each with and without reference marking, cover the packet length arithmetic and both sync shapes.

// File: rtl/vtd_pkg.sv
package vtd_pkg;
  localparam int VW = 10;
  typedef logic [VW-1:0] vword_t;

  // lowest value that still counts as the all-ones word (8-bit sources)
  localparam vword_t ONES_FLOOR = 10'h3FC;
  localparam int COMP_MARK_WORDS  = 4;
  localparam int COMPO_MARK_WORDS = 5;
  // words from the first header word to the count word
  localparam int HDR_TO_COUNT = 5;

  function automatic logic near_ones(vword_t w);
    return w >= ONES_FLOOR;
  endfunction

  function automatic logic is_null(vword_t w);
    return w == '0;
  endfunction

  function automatic logic ref_at(vword_t w0, vword_t w1, vword_t w2);
    return near_ones(w0) && is_null(w1) && is_null(w2);
  endfunction

  function automatic logic hdr_at(vword_t w0, vword_t w1, vword_t w2);
    return is_null(w0) && near_ones(w1) && near_ones(w2);
  endfunction

  function automatic logic is_end_ref(vword_t status);
    return status[6];
  endfunction

  function automatic logic [8:0] tail_after_count(vword_t cnt_word);
    return {1'b0, cnt_word[7:0]} + 9'd1;
  endfunction

  function automatic logic [2:0] mark_tail(logic comp);
    return comp ? 3'(COMP_MARK_WORDS - 1) : 3'(COMPO_MARK_WORDS - 1);
  endfunction
endpackage

// File: rtl/vtd_pipe.sv
module vtd_pipe
  import vtd_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk,
  input  logic   rst_n,
  input  vword_t din,
  output vword_t tap [DEPTH]
);
  logic [DEPTH-1:0][VW-1:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else        stage <= {stage[DEPTH-2:0], din};
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_tap
      assign tap[i] = stage[i];
    end
  endgenerate
endmodule

// File: rtl/vtd_sync_track.sv
module vtd_sync_track
  import vtd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic comp_mode,
  input  logic trs_ind_en,
  input  logic ref_hit,
  input  logic end_ref,
  output logic hsync,
  output logic ind_mark
);
  logic       hs_q;
  logic       ind_q;
  logic [2:0] tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_q   <= 1'b0;
      ind_q  <= 1'b0;
      tail_q <= '0;
    end else begin
      if (comp_mode) begin
        if (ref_hit) hs_q <= end_ref;
      end else begin
        hs_q <= ref_hit;
      end
      if (ref_hit) begin
        tail_q <= mark_tail(comp_mode);
        ind_q  <= trs_ind_en;
      end else if (tail_q != '0) begin
        tail_q <= tail_q - 3'd1;
        ind_q  <= trs_ind_en;
      end else begin
        ind_q  <= 1'b0;
      end
    end
  end

  assign hsync    = hs_q;
  assign ind_mark = ind_q;
endmodule

// File: rtl/vtd_anc_track.sv
module vtd_anc_track
  import vtd_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   hdr_hit,
  input  vword_t cur_word,
  output logic   pkt_flag,
  output logic   pkt_start
);
  logic       open_q;
  logic       in_hdr_q;
  logic [8:0] left_q;
  logic       closing;
  logic       free;

  assign closing   = open_q && !in_hdr_q && (left_q == '0);
  assign free      = !open_q || closing;
  assign pkt_start = free && hdr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      in_hdr_q <= 1'b0;
      left_q   <= '0;
    end else if (free) begin
      open_q   <= hdr_hit;
      in_hdr_q <= hdr_hit;
      left_q   <= hdr_hit ? 9'(HDR_TO_COUNT) : '0;
    end else if (in_hdr_q && left_q == 9'd1) begin
      // the count word is the one entering the output stage
      in_hdr_q <= 1'b0;
      left_q   <= tail_after_count(cur_word);
    end else begin
      left_q   <= left_q - 9'd1;
    end
  end

  assign pkt_flag = open_q;
endmodule

// File: rtl/vtd_lock_mon.sv
module vtd_lock_mon #(
  parameter int GAP_WORDS = 2000,
  parameter int LOSS_RUN  = 7,
  parameter int LOCK_RUN  = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_hit,
  output logic miss_evt,
  output logic lost
);
  localparam int GAP_W   = $clog2(GAP_WORDS);
  localparam int RUN_MAX = (LOSS_RUN > LOCK_RUN) ? LOSS_RUN : LOCK_RUN;
  localparam int RUN_W   = $clog2(RUN_MAX + 1);

  logic [GAP_W-1:0] gap_q;
  logic [RUN_W-1:0] miss_q, good_q;
  logic             lost_q;

  assign miss_evt = !ref_hit && (gap_q == GAP_W'(GAP_WORDS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q  <= '0;
      miss_q <= '0;
      good_q <= '0;
      lost_q <= 1'b1;
    end else if (ref_hit) begin
      gap_q  <= '0;
      miss_q <= '0;
      if (int'(good_q) < LOCK_RUN) good_q <= good_q + 1'b1;
      if (int'(good_q) + 1 >= LOCK_RUN) lost_q <= 1'b0;
    end else if (miss_evt) begin
      gap_q  <= '0;
      good_q <= '0;
      if (int'(miss_q) < LOSS_RUN) miss_q <= miss_q + 1'b1;
      if (int'(miss_q) + 1 >= LOSS_RUN) lost_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  assign lost = lost_q;
endmodule

// File: rtl/vid_trs_anc_detect.sv
module vid_trs_anc_detect
  import vtd_pkg::*;
#(
  parameter int GAP_WORDS = 2000,
  parameter int LOSS_RUN  = 7,
  parameter int LOCK_RUN  = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       comp_mode,
  input  logic       trs_ind_en,
  input  logic [9:0] din,
  output logic [9:0] dout,
  output logic       hsync,
  output logic       anc_flag,
  output logic       no_trs
);
  // three words of lookahead plus the output register
  localparam int PIPE_DEPTH = 4;

  vword_t tap [PIPE_DEPTH];
  vword_t cur_w, ahead1, ahead2, ahead3;
  logic   trs_hit, hdr_hit, miss_evt, pkt_start;
  logic   pkt_flag, ind_mark;

  vtd_pipe #(.DEPTH(PIPE_DEPTH)) u_pipe (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (din),
    .tap  (tap)
  );

  // word about to move to the output, and the words behind it
  assign cur_w  = tap[PIPE_DEPTH-2];
  assign ahead1 = tap[PIPE_DEPTH-3];
  assign ahead2 = tap[PIPE_DEPTH-4];
  assign ahead3 = din;

  assign trs_hit = ref_at(cur_w, ahead1, ahead2);
  assign hdr_hit = hdr_at(cur_w, ahead1, ahead2);

  vtd_sync_track u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .comp_mode (comp_mode),
    .trs_ind_en(trs_ind_en),
    .ref_hit   (trs_hit),
    .end_ref   (is_end_ref(ahead3)),
    .hsync     (hsync),
    .ind_mark  (ind_mark)
  );

  vtd_anc_track u_anc (
    .clk      (clk),
    .rst_n    (rst_n),
    .hdr_hit  (hdr_hit),
    .cur_word (cur_w),
    .pkt_flag (pkt_flag),
    .pkt_start(pkt_start)
  );

  vtd_lock_mon #(
    .GAP_WORDS(GAP_WORDS),
    .LOSS_RUN (LOSS_RUN),
    .LOCK_RUN (LOCK_RUN)
  ) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .ref_hit (trs_hit),
    .miss_evt(miss_evt),
    .lost    (no_trs)
  );

  assign dout     = tap[PIPE_DEPTH-1];
  assign anc_flag = pkt_flag | ind_mark;
endmodule

// File: rtl/vtd_checker.sv
module vtd_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       comp_mode,
  input logic       trs_ind_en,
  input logic [9:0] din,
  input logic [9:0] dout,
  input logic       hsync,
  input logic       anc_flag,
  input logic       no_trs,
  input logic       trs_hit,
  input logic       miss_evt
);
  logic [2:0] live_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                live_cnt <= '0;
    else if (live_cnt != 3'd4) live_cnt <= live_cnt + 3'd1;
  end

  assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (live_cnt == 3'd4) |-> (dout == $past(din, 4)));

  assert_end_ref_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hsync) && $past(comp_mode)) |-> (dout >= 10'h3FC));

  assert_pulse_on_ref_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hsync && !$past(comp_mode)) |-> (dout >= 10'h3FC));

  assert_pkt_opens_on_null_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(anc_flag) && !$past(trs_ind_en)) |-> (dout == 10'h000));

  assert_loss_after_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(no_trs) |-> $past(miss_evt));

  assert_lock_after_ref_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(no_trs) |-> $past(trs_hit));

  assert_reset_state_R9: assert property (@(posedge clk)
    !rst_n |=> (no_trs && !hsync && !anc_flag && dout == 10'h000));
endmodule

bind vid_trs_anc_detect vtd_checker u_vtd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .comp_mode (comp_mode),
  .trs_ind_en(trs_ind_en),
  .din       (din),
  .dout      (dout),
  .hsync     (hsync),
  .anc_flag  (anc_flag),
  .no_trs    (no_trs),
  .trs_hit   (trs_hit),
  .miss_evt  (miss_evt)
);

// File: tb/vid_trs_anc_detect_tb.sv
module vid_trs_anc_detect_tb;
  localparam int GAP = 128;

  typedef struct packed {
    logic [9:0] w;
    logic       pkt;
    logic       trs;
    logic       mark;
    logic       hs;
  } ent_t;

  logic       clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       comp_mode = 1'b1;
  logic       trs_ind_en = 1'b0;
  logic [9:0] din = 10'h100;
  logic [9:0] dout;
  logic       hsync, anc_flag, no_trs;

  vid_trs_anc_detect #(.GAP_WORDS(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .comp_mode(comp_mode), .trs_ind_en(trs_ind_en),
    .din(din), .dout(dout), .hsync(hsync), .anc_flag(anc_flag), .no_trs(no_trs)
  );

  int          n_chk = 0, n_fail = 0;
  string       seg = "";
  bit          finished = 0;
  ent_t        genq[$];
  ent_t        pipeq[$];
  ent_t        cur = '{10'h100, 1'b0, 1'b0, 1'b0, 1'b0};
  logic        hs_state = 1'b0;
  int unsigned seed = 32'h1234;

  logic [9:0] e_dout;
  logic       e_hs, e_anc, e_nt;
  string      e_anc_tag = "R5";
  bit         model_live = 0;
  int         m_gap, m_miss, m_good;
  logic       m_lost;

  function automatic logic [9:0] rnd_word();
    seed = seed * 32'd1103515245 + 32'd12345;
    return 10'h040 + 10'((seed >> 8) % 32'h380);
  endfunction

  task automatic check(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s%s: actual=%0h expected=%0h", tag, what, seg, act, exp);
    end
  endtask

  task automatic push(logic [9:0] w, logic pkt, logic trs, logic mark, logic hs);
    genq.push_back('{w, pkt, trs, mark, hs});
  endtask

  task automatic filler(int n);
    for (int i = 0; i < n; i++) push(rnd_word(), 1'b0, 1'b0, 1'b0, comp_mode & hs_state);
  endtask

  // component reference: lead,000,000,status (bit 6 = H)
  task automatic comp_ref(logic is_end, logic [9:0] lead);
    push(lead,  1'b0, 1'b1, 1'b1, is_end);
    push(10'h0, 1'b0, 1'b0, 1'b1, is_end);
    push(10'h0, 1'b0, 1'b0, 1'b1, is_end);
    push(is_end ? 10'h274 : 10'h200, 1'b0, 1'b0, 1'b1, is_end);
    hs_state = is_end;
  endtask

  // composite reference: lead,000,000,000,id
  task automatic compo_ref(logic [9:0] lead);
    push(lead,   1'b0, 1'b1, 1'b1, 1'b1);
    push(10'h0,  1'b0, 1'b0, 1'b1, 1'b0);
    push(10'h0,  1'b0, 1'b0, 1'b1, 1'b0);
    push(10'h0,  1'b0, 1'b0, 1'b1, 1'b0);
    push(10'h0A0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic anc_pkt(int cnt, logic [9:0] lead);
    logic h;
    h = comp_mode & hs_state;
    push(10'h0, 1'b1, 1'b0, 1'b0, h);
    push(lead,  1'b1, 1'b0, 1'b0, h);
    push(10'h3FF, 1'b1, 1'b0, 1'b0, h);
    push(rnd_word(), 1'b1, 1'b0, 1'b0, h);
    push(rnd_word(), 1'b1, 1'b0, 1'b0, h);
    push(10'(cnt), 1'b1, 1'b0, 1'b0, h);
    for (int i = 0; i < cnt; i++) push(rnd_word(), 1'b1, 1'b0, 1'b0, h);
    push(rnd_word(), 1'b1, 1'b0, 1'b0, h);
  endtask

  task automatic comp_line(int k, logic [9:0] lead);
    comp_ref(1'b1, lead);
    filler(6);
    anc_pkt(k % 20, lead);
    filler(5);
    comp_ref(1'b0, lead);
    filler(30);
  endtask

  task automatic compo_line(int k);
    compo_ref(10'h3FF);
    filler(8);
    anc_pkt(k % 17, 10'h3FF);
    filler(40);
  endtask

  task automatic drain();
    while (genq.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    comp_mode = mode;
    hs_state = 1'b0;
    repeat (2) @(negedge clk);
    check("R9", "dout in reset", 16'(dout), 16'h0);
    check("R9", "hsync in reset", 16'(hsync), 16'h0);
    check("R9", "anc_flag in reset", 16'(anc_flag), 16'h0);
    check("R9", "no_trs in reset", 16'(no_trs), 16'h1);
    rst_n = 1'b1;
  endtask

  // stimulus driver
  always @(negedge clk) begin
    if (genq.size() != 0) cur = genq.pop_front();
    else cur = '{10'h100, 1'b0, 1'b0, 1'b0, comp_mode & hs_state};
    din = cur.w;
  end

  // reference model: per-word tags from the generator, integer lock counters
  always @(posedge clk) begin : model
    ent_t e;
    if (!rst_n) begin
      pipeq.delete();
      repeat (3) pipeq.push_back('0);
      m_gap = 0; m_miss = 0; m_good = 0; m_lost = 1'b1;
      e_dout = '0; e_hs = 1'b0; e_anc = 1'b0; e_nt = 1'b1; e_anc_tag = "R9";
      model_live = 1;
    end else if (model_live) begin
      pipeq.push_back(cur);
      e = pipeq.pop_front();
      e_dout = e.w;
      e_hs = e.hs;
      e_anc = e.pkt | (trs_ind_en & e.mark);
      e_anc_tag = (trs_ind_en & e.mark) ? "R6" : "R5";
      if (e.trs) begin
        m_gap = 0; m_miss = 0; m_good++;
        if (m_good >= 7) m_lost = 1'b0;
      end else if (m_gap == GAP - 1) begin
        m_gap = 0; m_good = 0; m_miss++;
        if (m_miss >= 7) m_lost = 1'b1;
      end else begin
        m_gap++;
      end
      e_nt = m_lost;
    end
  end

  always @(negedge clk) begin
    if (model_live && !finished) begin
      check("R1", "dout", 16'(dout), 16'(e_dout));
      check(comp_mode ? "R3" : "R4", "hsync", 16'(hsync), 16'(e_hs));
      check(e_anc_tag, "anc_flag", 16'(anc_flag), 16'(e_anc));
      check(e_nt ? "R7" : "R8", "no_trs", 16'(no_trs), 16'(e_nt));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset(1'b1);

    // component, packet marking only (R3, R5, R8)
    for (int k = 0; k < 10; k++) comp_line(k, 10'h3FF);
    drain();
    check("R8", "no_trs after component lock", 16'(no_trs), 16'h0);

    // reference marking on (R6)
    trs_ind_en = 1'b1;
    for (int k = 10; k < 14; k++) comp_line(k, 10'h3FF);
    drain();

    // 8-bit style leading words (R2)
    seg = " [R2]";
    comp_line(3, 10'h3FC);
    comp_line(7, 10'h3FD);
    comp_line(0, 10'h3FE);
    trs_ind_en = 1'b0;
    comp_line(19, 10'h3FC);
    // corrupted reference: third word not zero, must not count
    comp_ref(1'b1, 10'h3FF);
    push(10'h3FF, 1'b0, 1'b0, 1'b0, 1'b1);
    push(10'h000, 1'b0, 1'b0, 1'b0, 1'b1);
    push(10'h001, 1'b0, 1'b0, 1'b0, 1'b1);
    push(10'h200, 1'b0, 1'b0, 1'b0, 1'b1);
    filler(20);
    comp_ref(1'b0, 10'h3FF);
    filler(20);
    drain();
    seg = "";

    // full loss (R7)
    filler(8 * GAP + 20);
    drain();
    check("R7", "no_trs after seven misses", 16'(no_trs), 16'h1);

    // six references then one miss: streak broken (R8)
    for (int k = 0; k < 3; k++) comp_line(k, 10'h3FF);
    filler(GAP + 10);
    drain();
    check("R8", "no_trs held after broken streak", 16'(no_trs), 16'h1);
    for (int k = 0; k < 4; k++) comp_line(k + 4, 10'h3FF);
    drain();
    check("R8", "no_trs cleared after seven references", 16'(no_trs), 16'h0);

    // three misses only: lock kept (R7)
    filler(3 * GAP);
    for (int k = 0; k < 2; k++) comp_line(k, 10'h3FF);
    drain();
    check("R7", "no_trs low after three misses", 16'(no_trs), 16'h0);

    // composite mode with reference marking (R4, R6)
    trs_ind_en = 1'b1;
    do_reset(1'b0);
    for (int k = 0; k < 8; k++) compo_line(k);
    drain();
    check("R8", "no_trs after composite lock", 16'(no_trs), 16'h0);
    trs_ind_en = 1'b0;
    for (int k = 8; k < 12; k++) compo_line(k);
    drain();

    // reset in mid stream (R9)
    do_reset(1'b1);
    comp_line(5, 10'h3FF);
    drain();

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule